// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Engine

This block is the target-side bit layer of a one-wire debug link. The pad is open-drain and pulled high, and the external host owns the start of every bit. The host starts a bit by pulling the line low. The engine runs on the local E-clock, passes the line through a synchronizer and detects the host's falling edge.

When the engine is receiving, it reads the line at a fixed point after that edge and takes the level as the data bit. When it is transmitting, it ends the bit the host started. For a zero it holds the line low, drives it high for one cycle to speed up the rising edge, and then releases it. For a one it never pulls the line down.

Whole bytes move MSB first between the engine and a command layer. Outgoing bytes enter through a valid/ready pair and incoming bytes leave through another. A one-cycle strobe marks the end of every byte in either direction. The engine drives the pad through two outputs, a drive enable and a drive value. Opcode decoding, memory access and the analog pad are outside this block.

Top module: `debug_wire_bit_engine`

## Requirements
- R1: After reset, and after any reset applied in the middle of a bit, `drive_en`=0, `tx_ready`=1, `rx_valid`=0 and `byte_done`=0. The line input is taken to be idle high.
- R2: Clock edge k is the first edge at which the line is seen low. In a transmitted zero bit, `drive_en`=1 and `drive_val`=0 in the cycles that start at edges k+2 through k+12. The line is therefore low at the host's sample point near cycle 10.
- R3: In a transmitted zero bit, the cycle that starts at edge k+13 has `drive_en`=1 and `drive_val`=1. From edge k+14 onward `drive_en`=0.
- R4: In a transmitted one bit, and in every received bit, `drive_en` stays 0.
- R5: A received bit is the line level present just before edge k+10. A host that holds the line low through edge k+12 sends a 0, and a host that releases it by edge k+4 sends a 1.
- R6: Bytes are transmitted and received MSB first. Bit 7 of `tx_data` goes out in the first bit after the byte is accepted, and the first bit received lands in bit 7 of `rx_data`.
- R7: `byte_done` is high for exactly the one cycle that starts at edge k+14 of the eighth bit of a byte, in both directions.
- R8: `rx_valid` rises together with `byte_done` at the end of a received byte and stays high until a cycle with `rx_ready`=1. A byte that completes while an earlier one is pending overwrites `rx_data` and keeps `rx_valid` high. This also holds when `rx_ready` is high in the completing cycle.
- R9: `tx_ready` is high only between bytes, with no bit in progress and no byte loaded. A byte that is accepted on the same edge at which a host edge is detected (edge k+2) is sent starting with that bit.
- R10: A falling edge on the line while a bit is in progress does not start a new bit and does not disturb the bit being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local E-clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Level of the debug line, asynchronous |
| drive_en | output | 1 | Pad output enable |
| drive_val | output | 1 | Level driven while enabled |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine can accept a transmit byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Command layer takes the received byte |
| byte_done | output | 1 | One-cycle strobe at the end of each byte |

## Verification
Two actions can meet in one cycle: the commit of a newly received byte and the command layer's pop of the byte still pending. The bench leaves one byte unread and then raises `rx_ready` in exactly the cycle that ends at the commit edge of the next byte. It then expects `rx_valid` still high with the new byte. A second meeting is a transmit byte offered on the edge where the host's falling edge is detected. The bench judges it by reading that byte's MSB off the line in the same bit.

// File: rtl/owbe_pkg.sv
// Shared types for the single-wire bit engine.
package owbe_pkg;
    // Bit phase: waiting for a host edge, or inside a bit time.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BIT  = 1'b1
    } phase_e;
endpackage

// File: rtl/owbe_line_sync.sv
// Synchronizes the asynchronous debug line and flags its falling edges.
// Assumes the line idles high, so every stage resets to 1.
// The edge flag is valid SYNC_STAGES-1 cycles after the first stage sees the low.
module owbe_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // First stage captures the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= line_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_stage
            // Each later stage re-times the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= 1'b1;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    assign line_s = chain[SYNC_STAGES-1];

    // Remembers the synchronized level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= line_s;
    end

    assign fall = prev & ~line_s;
endmodule

// File: rtl/owbe_bit_timer.sv
// Times one bit from the host's falling edge. It samples the line for receive
// and shapes the pad drive for a transmitted zero (hold low, then a one-cycle
// high pulse). Counter value n means the n-th cycle after the host edge.
// Assumes send_zero is stable for the whole bit.
module owbe_bit_timer
    import owbe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYCLES  = 13,
    parameter int SAMPLE_AT   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic line_s,
    input  logic send_zero,
    output logic bit_active,
    output logic bit_end,
    output logic rx_bit,
    output logic drive_en,
    output logic drive_val
);
    localparam int CNT_W = $clog2(LOW_CYCLES + 3);
    localparam logic [CNT_W-1:0] CNT_START  = CNT_W'(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] CNT_SPEED  = CNT_W'(LOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_SAMPLE = CNT_W'(SAMPLE_AT + SYNC_STAGES);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    // Phase and counter: start on a host edge, stop after the speed-up cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (fall) begin
                    phase <= PH_BIT;
                    cnt   <= CNT_START;
                end
                default: if (cnt == CNT_SPEED) phase <= PH_IDLE;
                         else                  cnt   <= cnt + 1'b1;
            endcase
        end
    end

    // Captures the received level at the fixed sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rx_bit <= 1'b1;
        else if (phase == PH_BIT && cnt == CNT_SAMPLE) rx_bit <= line_s;
    end

    assign bit_active = (phase == PH_BIT);
    assign bit_end    = bit_active && (cnt == CNT_SPEED);
    assign drive_en   = bit_active && send_zero;
    assign drive_val  = bit_end;

    // R3
    speedup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && drive_val) |=> !drive_en);
    // R2
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !drive_val) |=> drive_en);
    // R2
    low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> !drive_val);
endmodule

// File: rtl/owbe_byte_shifter.sv
// Holds the byte in flight, MSB first, in either direction, and runs the
// valid/ready exchange with the command layer. A loaded transmit byte selects
// transmit; otherwise bits are received. A new receive byte overwrites one
// that is still pending.
module owbe_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic              bit_active,
    input  logic              bit_end,
    input  logic              rx_bit,
    output logic              send_zero,
    output logic              byte_done
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              tx_mode;
    logic              load;

    assign tx_ready  = !bit_active && (idx == '0) && !tx_mode;
    assign load      = tx_valid && tx_ready;
    assign send_zero = tx_mode && !shreg[DATA_W-1];

    // Shift, bit index, direction and receive handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            idx       <= '0;
            tx_mode   <= 1'b0;
            byte_done <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (load) begin
                shreg   <= tx_data;
                tx_mode <= 1'b1;
            end else if (bit_end) begin
                shreg <= {shreg[DATA_W-2:0], tx_mode ? 1'b0 : rx_bit};
                if (idx == IDX_LAST) begin
                    idx       <= '0;
                    byte_done <= 1'b1;
                    tx_mode   <= 1'b0;
                    if (!tx_mode) begin
                        rx_data  <= {shreg[DATA_W-2:0], rx_bit};
                        rx_valid <= 1'b1;
                    end
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);
    // R8
    rx_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> byte_done);
endmodule

// File: rtl/debug_wire_bit_engine.sv
// Target-side bit engine for a host-clocked single-wire debug line.
// Chain: line synchronizer -> bit timer -> byte shifter. The pad is driven
// through drive_en/drive_val; the outside pull-up supplies the idle high.
module debug_wire_bit_engine #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYCLES  = 13,
    parameter int SAMPLE_AT   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              drive_en,
    output logic              drive_val,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              byte_done
);
    logic line_s, fall, bit_active, bit_end, rx_bit, send_zero;

    owbe_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .line_s(line_s), .fall(fall)
    );

    owbe_bit_timer #(
        .SYNC_STAGES(SYNC_STAGES), .LOW_CYCLES(LOW_CYCLES), .SAMPLE_AT(SAMPLE_AT)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .fall(fall), .line_s(line_s),
        .send_zero(send_zero), .bit_active(bit_active), .bit_end(bit_end),
        .rx_bit(rx_bit), .drive_en(drive_en), .drive_val(drive_val)
    );

    owbe_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .bit_active(bit_active), .bit_end(bit_end),
        .rx_bit(rx_bit), .send_zero(send_zero), .byte_done(byte_done)
    );

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !drive_en);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !drive_en);
endmodule

// File: tb/debug_wire_bit_engine_tb.sv
`timescale 1ns/1ps
module debug_wire_bit_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       drive_en, drive_val, tx_ready, rx_valid, byte_done;
    logic [7:0] tx_data = 8'h00, rx_data;
    logic       tx_valid = 1'b0, rx_ready = 1'b0;
    logic       line_w;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign line_w = host_low ? 1'b0 : (drive_en ? drive_val : 1'b1);

    debug_wire_bit_engine u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_w),
        .drive_en(drive_en), .drive_val(drive_val),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .byte_done(byte_done)
    );

    // bit 8: 1 = target transmits, 0 = host sends; bits 7:0 = byte
    localparam logic [8:0] VEC [6] = '{
        {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h00},
        {1'b0, 8'hFF}, {1'b1, 8'hFF}, {1'b0, 8'h81}
    };

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One bit: host edge lands just before edge k; loop index j = interval k+j.
    task automatic host_bit(input logic val, input logic exp_zero, input logic glitch,
                            input logic late, input logic [7:0] late_d, input logic pop13,
                            output logic seen, output logic pat_ok, output logic done_at14);
        @(negedge clk) host_low = 1'b1;
        pat_ok = 1'b1; seen = 1'b1; done_at14 = 1'b0;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (j == 3 && val)  host_low = 1'b0;
            if (j == 12 && !val) host_low = 1'b0;
            if (glitch && j == 5) host_low = 1'b1;
            if (glitch && j == 7) host_low = 1'b0;
            if (late && j == 1) begin tx_data = late_d; tx_valid = 1'b1; end
            if (late && j == 2) tx_valid = 1'b0;
            if (pop13 && j == 13) rx_ready = 1'b1;
            if (pop13 && j == 14) rx_ready = 1'b0;
            if (j == 9) seen = line_w;
            if (j == 14) done_at14 = byte_done;
            if (j == 15 && byte_done) pat_ok = 1'b0;
            if (j >= 2 && j <= 12) begin
                if (drive_en !== exp_zero || (exp_zero && drive_val !== 1'b0)) pat_ok = 1'b0;
            end else if (j == 13) begin
                if (drive_en !== exp_zero || (exp_zero && drive_val !== 1'b1)) pat_ok = 1'b0;
            end else if (drive_en !== 1'b0) pat_ok = 1'b0;
        end
    endtask

    task automatic run_byte(input logic is_tx, input logic [7:0] d, input logic late,
                            input logic pop13, input logic glitch,
                            output logic [7:0] got, output logic pat_all, output logic done_ok);
        logic s, p, dn;
        pat_all = 1'b1; done_ok = 1'b1;
        for (int b = 7; b >= 0; b--) begin
            host_bit(is_tx ? 1'b1 : d[b], is_tx && !d[b], glitch && !is_tx && d[b],
                     late && b == 7, d, pop13 && b == 0, s, p, dn);
            got[b] = s;
            pat_all &= p;
            if (dn !== (b == 0)) done_ok = 1'b0;
        end
    endtask

    task automatic load_tx(input logic [7:0] d);
        @(negedge clk);
        check(tx_ready === 1'b1, "R9", "tx_ready between bytes", tx_ready, 1);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk) tx_valid = 1'b0;
        check(tx_ready === 1'b0, "R9", "tx_ready after load", tx_ready, 0);
    endtask

    task automatic pop_rx;
        @(negedge clk) rx_ready = 1'b1;
        @(negedge clk) rx_ready = 1'b0;
        check(rx_valid === 1'b0, "R8", "rx_valid after pop", rx_valid, 0);
    endtask

    initial begin : watchdog
        #600000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        logic [7:0] got;
        logic pat, dn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(drive_en === 1'b0 && byte_done === 1'b0, "R1", "drive/done at reset",
              {drive_en, byte_done}, 0);
        check(tx_ready === 1'b1 && rx_valid === 1'b0, "R1", "ready/valid at reset",
              {tx_ready, rx_valid}, 2);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][8]) begin
                load_tx(VEC[v][7:0]);
                run_byte(1'b1, VEC[v][7:0], 1'b0, 1'b0, 1'b0, got, pat, dn);
                check(got === VEC[v][7:0], "R6", "tx byte on line", got, VEC[v][7:0]);
                check(pat, "R2/R3/R4", "tx drive shape", pat, 1);
            end else begin
                run_byte(1'b0, VEC[v][7:0], 1'b0, 1'b0, 1'b0, got, pat, dn);
                check(pat, "R4", "no drive while receiving", pat, 1);
                check(rx_valid === 1'b1 && rx_data === VEC[v][7:0], "R5/R6", "rx byte",
                      rx_data, VEC[v][7:0]);
                pop_rx();
            end
            check(dn, "R7", "byte_done only after 8th bit", dn, 1);
        end

        // R8 overwrite while pending
        run_byte(1'b0, 8'h12, 1'b0, 1'b0, 1'b0, got, pat, dn);
        run_byte(1'b0, 8'h34, 1'b0, 1'b0, 1'b0, got, pat, dn);
        check(rx_valid === 1'b1 && rx_data === 8'h34, "R8", "overwrite pending", rx_data, 8'h34);
        // R8 pop in the same cycle as the commit
        run_byte(1'b0, 8'h5A, 1'b0, 1'b1, 1'b0, got, pat, dn);
        check(rx_valid === 1'b1 && rx_data === 8'h5A, "R8", "pop meets commit", rx_data, 8'h5A);
        pop_rx();

        // R9 byte accepted on the edge where the host edge is detected
        @(negedge clk);
        check(tx_ready === 1'b1, "R9", "ready before late load", tx_ready, 1);
        run_byte(1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, got, pat, dn);
        check(got === 8'hC3, "R9", "late-loaded byte on line", got, 8'hC3);
        check(pat, "R2/R3", "late-load drive shape", pat, 1);

        // R10 extra falling edge inside a bit
        run_byte(1'b0, 8'hB7, 1'b0, 1'b0, 1'b1, got, pat, dn);
        check(rx_valid === 1'b1 && rx_data === 8'hB7, "R10", "glitch ignored", rx_data, 8'hB7);
        check(dn, "R10", "bit count unchanged by glitch", dn, 1);
        pop_rx();

        // R1 reset in the middle of a transmitted zero
        load_tx(8'h00);
        @(negedge clk) host_low = 1'b1;
        repeat (6) @(negedge clk);
        check(drive_en === 1'b1, "R2", "driving before reset", drive_en, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(drive_en === 1'b0 && tx_ready === 1'b1, "R1", "mid-bit reset",
              {drive_en, tx_ready}, 1);
        host_low = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(rx_valid === 1'b0 && byte_done === 1'b0, "R1", "after mid-bit reset",
              {rx_valid, byte_done}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule